// File: doc/BRIEF.md
# Scan-Locked Analog Output Sequencer

This block refreshes four serial DAC channels and a parallel digital pattern word as one update event. Output data arrives on a valid/ready word stream fed from a host-side buffer. The block collects one frame of five words: the pattern word comes first, then the four DAC words. When an update strobe arrives and a full frame is held, the pattern is registered at once. The four DAC words are then shifted out on a serial link, MSB first and channel 0 first, and a load pulse follows the last bit.

The update strobe comes from one of three sources. The first is the acquisition scan-start pulse, which keeps the outputs locked to the input scans. The second is an internal pacer that divides the system clock. The third is an external pacer pin, which is synchronized and edge-detected. Two sticky flags record problems. One marks a strobe that found too few words. The other marks a strobe that arrived while shifting was still in progress.

Top module: `aout_sequencer`

## Requirements
- R1: Stream words are taken into the frame in arrival order. The first word of a frame becomes the pattern, and words two to five become DAC channels 0 to 3.
- R2: On the clock edge where an accepted strobe is high, pattern_out takes the frame's pattern word. At that same edge dac_cs_n goes low. pattern_out changes at no other time.
- R3: While dac_cs_n is low, 64 bits are sent. They are presented on dac_sdo and sampled on the rising edge of dac_sclk. Each bit takes two clock cycles. The order is channel 0 through 3, and each channel is sent MSB first.
- R4: dac_load is a one-cycle pulse. It rises together with dac_cs_n returning high, 129 clock cycles after the strobe edge.
- R5: An update completes within MAX_UPDATE_CYCLES clock cycles. The default is 800 cycles, which is 4 µs at 200 MHz.
- R6: When src_sel=0, each scan_start pulse is an update strobe.
- R7: When src_sel=1, the internal pacer strobes every pacer_div+1 cycles.
- R8: When src_sel=2, each rising edge on ext_pacer gives exactly one update, however long the pin then stays high.
- R9: A strobe that finds fewer than five words held leaves all outputs unchanged and sets the sticky underrun flag. The words already held stay in the frame.
- R10: A strobe that arrives while shifting is in progress is ignored and sets the sticky overrun flag. The shift in progress and the held frame are not affected.
- R11: s_ready is low exactly while five words are held. Words offered while s_ready is low are not taken.
- R12: After reset: pattern_out=0, dac_cs_n=1, dac_sclk=0, dac_load=0, both flags are 0, and s_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Strobe source: 0 scan, 1 internal pacer, 2 external pacer, 3 none |
| scan_start | input | 1 | One-cycle acquisition scan-start pulse |
| pacer_div | input | 16 | Internal pacer period minus one |
| ext_pacer | input | 1 | Asynchronous external pacer pin |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 16 | Stream word |
| s_ready | output | 1 | Block can take a word |
| pattern_out | output | 16 | Parallel digital pattern |
| dac_sclk | output | 1 | Serial clock to DACs |
| dac_sdo | output | 1 | Serial data to DACs |
| dac_cs_n | output | 1 | Active-low DAC frame select |
| dac_load | output | 1 | One-cycle DAC load pulse |
| underrun | output | 1 | Sticky: strobe found an incomplete frame |
| overrun | output | 1 | Sticky: strobe arrived during shifting |

## Verification
A frame counter that is off by one slot shows up on the first update. Every word lands in the wrong place: the pattern shows a DAC word, and the 64 captured serial bits are rotated by one channel. A serializer bit counter that stops too early or too late moves the load pulse away from cycle 129 and leaves fewer or more than 64 sampled bits. A busy state that clears too early lets an overrun strobe restart the shift, which breaks the captured words of the frame in flight. A missing synchronizer edge detector gives repeated updates while ext_pacer stays high, and these show up within one pacer-hold window.

// File: rtl/aoseq_pkg.sv
package aoseq_pkg;
  typedef enum logic [1:0] {
    SRC_SCAN  = 2'd0,
    SRC_PACER = 2'd1,
    SRC_EXT   = 2'd2,
    SRC_NONE  = 2'd3
  } upd_src_e;
endpackage

// File: rtl/aoseq_strobe_sel.sv
module aoseq_strobe_sel
  import aoseq_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  upd_src_e         src,
  input  logic             scan_start,
  input  logic [DIV_W-1:0] pacer_div,
  input  logic             ext_pacer,
  output logic             strobe
);
  logic [DIV_W-1:0]     pace_cnt;
  logic                 pace_tick;
  logic [SYNC_STAGES:0] ext_sh;
  logic                 ext_tick;

  // internal pacer: held at zero unless selected, so its phase is defined
  always_ff @(posedge clk) begin
    if (rst || src != SRC_PACER) begin
      pace_cnt  <= '0;
      pace_tick <= 1'b0;
    end else if (pace_cnt == pacer_div) begin
      pace_cnt  <= '0;
      pace_tick <= 1'b1;
    end else begin
      pace_cnt  <= pace_cnt + 1'b1;
      pace_tick <= 1'b0;
    end
  end

  // external pacer: synchronizer chain plus one extra stage for edge detect
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_sh   <= '0;
      ext_tick <= 1'b0;
    end else begin
      ext_sh   <= {ext_sh[SYNC_STAGES-1:0], ext_pacer};
      ext_tick <= ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES];
    end
  end

  always_comb begin
    unique case (src)
      SRC_SCAN:  strobe = scan_start;
      SRC_PACER: strobe = pace_tick;
      SRC_EXT:   strobe = ext_tick;
      default:   strobe = 1'b0;
    endcase
  end
endmodule

// File: rtl/aoseq_serializer.sv
module aoseq_serializer #(
  parameter int DAC_CH = 4,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [DAC_CH*WORD_W-1:0] words,
  output logic                     busy,
  output logic                     sclk,
  output logic                     sdo,
  output logic                     cs_n,
  output logic                     load
);
  localparam int TOTAL = DAC_CH * WORD_W;
  localparam int BC_W  = $clog2(TOTAL);

  logic [TOTAL-1:0] shreg;
  logic [BC_W-1:0]  bit_cnt;
  logic             phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      load    <= 1'b0;
      phase   <= 1'b0;
      bit_cnt <= '0;
      shreg   <= '0;
    end else begin
      load <= 1'b0;
      if (start && !busy) begin
        shreg   <= words;
        busy    <= 1'b1;
        cs_n    <= 1'b0;
        sclk    <= 1'b0;
        phase   <= 1'b0;
        bit_cnt <= '0;
      end else if (busy) begin
        if (!phase) begin
          sclk  <= 1'b1;
          phase <= 1'b1;
        end else begin
          sclk  <= 1'b0;
          phase <= 1'b0;
          shreg <= shreg << 1;
          if (bit_cnt == BC_W'(TOTAL-1)) begin
            busy <= 1'b0;
            cs_n <= 1'b1;
            load <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
      end
    end
  end

  assign sdo = shreg[TOTAL-1];
endmodule

// File: rtl/aout_sequencer.sv
module aout_sequencer
  import aoseq_pkg::*;
#(
  parameter int DAC_CH            = 4,
  parameter int WORD_W            = 16,
  parameter int DIV_W             = 16,
  parameter int SYNC_STAGES       = 2,
  parameter int MAX_UPDATE_CYCLES = 800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        src_sel,
  input  logic              scan_start,
  input  logic [DIV_W-1:0]  pacer_div,
  input  logic              ext_pacer,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic [WORD_W-1:0] pattern_out,
  output logic              dac_sclk,
  output logic              dac_sdo,
  output logic              dac_cs_n,
  output logic              dac_load,
  output logic              underrun,
  output logic              overrun
);
  localparam int FRAME = DAC_CH + 1;
  localparam int CNT_W = $clog2(FRAME + 1);

  logic [WORD_W-1:0]        fbuf [FRAME];
  logic [CNT_W-1:0]         wcnt, wcnt_nxt;
  logic                     strobe, ser_busy, full, take, start;
  logic [DAC_CH*WORD_W-1:0] dac_words;

  aoseq_strobe_sel #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk(clk), .rst(rst), .src(upd_src_e'(src_sel)), .scan_start(scan_start),
    .pacer_div(pacer_div), .ext_pacer(ext_pacer), .strobe(strobe));

  assign full  = (wcnt == CNT_W'(FRAME));
  assign take  = s_valid && s_ready;
  assign start = strobe && !ser_busy && full;

  always_comb begin
    wcnt_nxt = wcnt;
    if (start)     wcnt_nxt = '0;
    else if (take) wcnt_nxt = wcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (take) fbuf[wcnt] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt        <= '0;
      s_ready     <= 1'b1;
      pattern_out <= '0;
      underrun    <= 1'b0;
      overrun     <= 1'b0;
    end else begin
      wcnt    <= wcnt_nxt;
      s_ready <= (wcnt_nxt != CNT_W'(FRAME));
      if (start)                        pattern_out <= fbuf[0];
      if (strobe && ser_busy)           overrun     <= 1'b1;
      else if (strobe && !full)         underrun    <= 1'b1;
    end
  end

  // channel 0 occupies the most significant slice, so it leaves first
  for (genvar g = 0; g < DAC_CH; g++) begin : g_pack
    assign dac_words[(DAC_CH-g)*WORD_W-1 -: WORD_W] = fbuf[g+1];
  end

  aoseq_serializer #(.DAC_CH(DAC_CH), .WORD_W(WORD_W)) u_ser (
    .clk(clk), .rst(rst), .start(start), .words(dac_words), .busy(ser_busy),
    .sclk(dac_sclk), .sdo(dac_sdo), .cs_n(dac_cs_n), .load(dac_load));
endmodule

// File: rtl/aoseq_checker.sv
module aoseq_checker #(
  parameter int WORD_W            = 16,
  parameter int MAX_UPDATE_CYCLES = 800
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] pattern_out,
  input logic              dac_sclk,
  input logic              dac_cs_n,
  input logic              dac_load,
  input logic              underrun,
  input logic              overrun
);
  logic [31:0] win;

  always_ff @(posedge clk) begin
    if (rst || dac_cs_n) win <= '0;
    else                 win <= win + 1;
  end

  // R2: pattern moves only at the start of a serial frame
  p_pattern_with_frame_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pattern_out) |-> (!dac_cs_n && $past(dac_cs_n)));

  // R3: serial clock toggles only inside a selected frame
  p_sclk_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
    dac_sclk |-> !dac_cs_n);

  // R4: load is a single cycle, issued with select released
  p_load_single_r4: assert property (@(posedge clk) disable iff (rst)
    dac_load |=> !dac_load);
  p_load_deselect_r4: assert property (@(posedge clk) disable iff (rst)
    dac_load |-> dac_cs_n);

  // R5: a frame never stays selected past the update window
  p_update_window_r5: assert property (@(posedge clk) disable iff (rst)
    !dac_cs_n |-> (win < MAX_UPDATE_CYCLES));

  // R9 / R10: flags are sticky
  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind aout_sequencer aoseq_checker #(
  .WORD_W(WORD_W), .MAX_UPDATE_CYCLES(MAX_UPDATE_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .pattern_out(pattern_out), .dac_sclk(dac_sclk),
  .dac_cs_n(dac_cs_n), .dac_load(dac_load), .underrun(underrun), .overrun(overrun));

// File: tb/test_aout_sequencer.sv
module test_aout_sequencer;
  localparam int W = 16;
  localparam int NB = 4 * W;

  logic clk = 0, rst = 1;
  logic [1:0] src_sel = 0;
  logic scan_start = 0, ext_pacer = 0, s_valid = 0;
  logic [15:0] pacer_div = 16'd199;
  logic [W-1:0] s_data = '0;
  logic s_ready, dac_sclk, dac_sdo, dac_cs_n, dac_load, underrun, overrun;
  logic [W-1:0] pattern_out;

  int nchk = 0, nfail = 0, nload = 0, nbits = 0, cyc = 0;
  logic [NB-1:0] cap = '0;

  always #2.5 clk = ~clk;

  aout_sequencer i_aout_sequencer (
    .clk(clk), .rst(rst), .src_sel(src_sel), .scan_start(scan_start),
    .pacer_div(pacer_div), .ext_pacer(ext_pacer), .s_valid(s_valid),
    .s_data(s_data), .s_ready(s_ready), .pattern_out(pattern_out),
    .dac_sclk(dac_sclk), .dac_sdo(dac_sdo), .dac_cs_n(dac_cs_n),
    .dac_load(dac_load), .underrun(underrun), .overrun(overrun));

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (dac_load) nload = nload + 1;
  end
  always @(negedge dac_cs_n) nbits = 0;
  always @(posedge dac_sclk) if (!dac_cs_n) begin
    cap = {cap[NB-2:0], dac_sdo};
    nbits = nbits + 1;
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [W-1:0] w);
    @(negedge clk); s_valid = 1; s_data = w;
    while (!s_ready) @(negedge clk);
    @(negedge clk); s_valid = 0;
  endtask

  task automatic push_frame(logic [W-1:0] base);
    for (int i = 0; i < 5; i++) push(base + W'(i));
  endtask

  function automatic logic [NB-1:0] dacs_of(logic [W-1:0] base);
    return {base + W'(1), base + W'(2), base + W'(3), base + W'(4)};
  endfunction

  task automatic pulse_scan();
    @(negedge clk); scan_start = 1;
    @(negedge clk); scan_start = 0;
  endtask

  task automatic wait_load(output int n);
    n = 1;
    while (!dac_load && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    check("R12 pattern", 64'(pattern_out), 0);
    check("R12 cs_n", 64'(dac_cs_n), 1);
    check("R12 sclk", 64'(dac_sclk), 0);
    check("R12 load", 64'(dac_load), 0);
    check("R12 flags", {62'd0, underrun, overrun}, 0);
    check("R12 ready", 64'(s_ready), 1);
  endtask

  task automatic t_scan();
    int n;
    push_frame(16'hA100);
    check("R11 ready low when full", 64'(s_ready), 0);
    pulse_scan();
    check("R1 R2 R6 pattern", 64'(pattern_out), 64'h A100);
    check("R2 cs_n low", 64'(dac_cs_n), 0);
    wait_load(n);
    check("R4 load cycle", 64'(n), 129);
    check("R5 window", 64'(n <= 800), 1);
    check("R3 bit count", 64'(nbits), 64);
    check("R1 R3 dac bits", cap, dacs_of(16'hA100));
    @(negedge clk);
    check("R4 single pulse", 64'(dac_load), 0);
  endtask

  task automatic t_underrun();
    push(16'hB100); push(16'hB101);
    pulse_scan();
    check("R9 flag", 64'(underrun), 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dac_cs_n !== 1'b1) check("R9 no shift", 64'(dac_cs_n), 1);
    end
    check("R9 pattern held", 64'(pattern_out), 64'hA100);
    push(16'hB102); push(16'hB103); push(16'hB104);
    pulse_scan();
    check("R9 kept words pattern", 64'(pattern_out), 64'hB100);
    begin int n; wait_load(n); end
    check("R9 kept words dacs", cap, dacs_of(16'hB100));
  endtask

  task automatic t_overrun();
    push_frame(16'hC100);
    pulse_scan();
    push_frame(16'hD100);
    check("R11 ready low", 64'(s_ready), 0);
    @(negedge clk); s_valid = 1; s_data = 16'hEEEE;
    repeat (3) @(negedge clk);
    s_valid = 0;
    check("R10 flag before", 64'(overrun), 0);
    pulse_scan();
    check("R10 flag", 64'(overrun), 1);
    check("R10 pattern kept", 64'(pattern_out), 64'hC100);
    begin int n; wait_load(n); end
    check("R10 shift intact", cap, dacs_of(16'hC100));
    pulse_scan();
    check("R10 R11 next pattern", 64'(pattern_out), 64'hD100);
    begin int n; wait_load(n); end
    check("R10 R11 next dacs", cap, dacs_of(16'hD100));
  endtask

  task automatic t_pacer();
    int t1, t2;
    push_frame(16'h5100);
    @(negedge clk); src_sel = 2'd1;
    while (dac_cs_n) @(negedge clk);
    t1 = cyc;
    check("R7 pattern", 64'(pattern_out), 64'h5100);
    push_frame(16'h6100);
    while (!dac_cs_n) @(negedge clk);
    while (dac_cs_n) @(negedge clk);
    t2 = cyc;
    src_sel = 2'd3;
    check("R7 period", 64'(t2 - t1), 200);
    begin int n; wait_load(n); end
    check("R7 dacs", cap, dacs_of(16'h6100));
  endtask

  task automatic t_ext();
    int l0;
    push_frame(16'h7100);
    @(negedge clk); src_sel = 2'd2;
    l0 = nload;
    ext_pacer = 1;
    repeat (200) @(negedge clk);
    check("R8 one update", 64'(nload - l0), 1);
    check("R8 pattern", 64'(pattern_out), 64'h7100);
    push_frame(16'h8100);
    repeat (200) @(negedge clk);
    check("R8 level no retrigger", 64'(nload - l0), 1);
    ext_pacer = 0;
    repeat (10) @(negedge clk);
    ext_pacer = 1;
    repeat (200) @(negedge clk);
    check("R8 second edge", 64'(nload - l0), 2);
    check("R8 dacs", cap, dacs_of(16'h8100));
    src_sel = 2'd0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_scan();
    t_underrun();
    t_overrun();
    t_pacer();
    t_ext();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule